// File: doc/BRIEF.md
# Online Randomness Health Monitor

This block sits beside an entropy source and checks its output continuously. It takes a serial stream of raw bits, each marked by a valid strobe, and the conditioned output words, each marked by their own valid strobe. Three statistical tests run over consecutive, non-overlapping windows of 20,000 valid bits: a count of ones, a chi-square statistic on 4-bit groups, and a tally of run lengths. Three repetition checks run without regard to window edges: a long-run alarm, a noise alarm on a longer run, and a check for an output word that repeats the one before it.

Each test reports through its own single-cycle pulse. A window-done pulse marks the cycle in which the three window verdicts are presented. All acceptance limits are fixed parameters. The surrounding logic decides what a failure means, such as shutting the source down or discarding the data.

Top module: `rng_health_mon`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, every output is low, whatever the strobes carry.
- R2: A window is 20,000 accepted bits. A bit is accepted only on a cycle with `bit_vld` high. `win_done` is high for exactly one cycle, the cycle after the edge that accepts the last bit of a window. The next accepted bit starts a new window with all window counts at zero.
- R3: `fail_monobit` pulses with `win_done` when the number of ones in the window is below 9655 or above 10345.
- R4: `fail_poker` pulses with `win_done` when the statistic S = 16·Σc² − 25,000,000 lies outside 5150..287000 inclusive. The window is split into 5000 groups of 4 consecutive accepted bits. The earliest bit of a group is its most significant bit. c is the number of groups that hold each of the 16 values.
- R5: `fail_runs` pulses with `win_done` when any run count lies outside its bounds. Runs are maximal blocks of equal bits inside the window. The run that ends the window is counted, and no run spans two windows. Runs of ones and runs of zeros are counted separately, in six classes: lengths 1, 2, 3, 4, 5, and 6 or more. The bounds for both polarities are 2267..2733, 1079..1421, 502..748, 223..402, 90..223 and 90..223.
- R6: `fail_longrun` pulses once, one cycle after the 34th consecutive identical accepted bit. Further identical bits do not repeat the pulse, and the count carries across window boundaries.
- R7: `fail_noise` pulses once, one cycle after the 48th consecutive identical accepted bit. It follows the same counting rules as R6.
- R8: `fail_stuck` pulses one cycle after a `word_vld` cycle whose `word_in` equals the previous valid word. The first valid word after reset never fails. `word_in` is ignored on cycles with `word_vld` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | `bit_in` carries a new raw bit |
| bit_in | input | 1 | Raw entropy bit |
| word_vld | input | 1 | `word_in` carries a new output word |
| word_in | input | 32 | Output word under test |
| win_done | output | 1 | Window verdicts are valid this cycle |
| fail_monobit | output | 1 | Ones-count test failed |
| fail_poker | output | 1 | 4-bit group chi-square test failed |
| fail_runs | output | 1 | Run-length distribution test failed |
| fail_longrun | output | 1 | 34 identical bits seen |
| fail_noise | output | 1 | 48 identical bits seen |
| fail_stuck | output | 1 | Output word repeated |

## Verification
Every output is a register loaded at the edge that accepts the bit or word causing it. So each result, including the three window verdicts, is due exactly one cycle after that stimulus. The bench drives inputs at the falling edge and samples all seven outputs 1 ns after the next rising edge. It compares them with values that a bench model predicted for that very edge. The window verdicts are computed by functions over the bench's stored copy of the window. The repetition and word checks come from counters kept in the bench, so an output that is early or late by one cycle shows up as a mismatch.

// File: rtl/rng_health_mon.sv
module rng_health_mon #(
  parameter int WIN_BITS  = 20000,
  parameter int WORD_W    = 32,
  parameter int LONG_RUN  = 34,
  parameter int NOISE_RUN = 48,
  parameter int ONES_LO   = 9655,
  parameter int ONES_HI   = 10345,
  parameter int POKER_LO  = 5150,
  parameter int POKER_HI  = 287000,
  parameter int RUN_LO [6] = '{2267, 1079, 502, 223, 90, 90},
  parameter int RUN_HI [6] = '{2733, 1421, 748, 402, 223, 223}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_in,
  output logic              win_done,
  output logic              fail_monobit,
  output logic              fail_poker,
  output logic              fail_runs,
  output logic              fail_longrun,
  output logic              fail_noise,
  output logic              fail_stuck
);
  localparam int CW  = $clog2(WIN_BITS + 1);
  localparam int NIB = WIN_BITS / 4;
  localparam int NW  = $clog2(NIB + 1);
  localparam int SW  = 2 * NW + 1;
  localparam int RW  = $clog2(NOISE_RUN + 1);
  localparam longint PK_LO_T = longint'(NIB) * NIB + POKER_LO;
  localparam longint PK_HI_T = longint'(NIB) * NIB + POKER_HI;

  logic [CW-1:0] pos, ones;
  logic [2:0]    nsh;
  logic [NW-1:0] pk [16];
  logic [SW-1:0] sumsq;
  logic [CW-1:0] rc [12];
  logic          wr_bit;
  logic [2:0]    wr_len;
  logic          rep_seen, rep_bit;
  logic [RW-1:0] rep_len;
  logic              prev_ok;
  logic [WORD_W-1:0] prev_word;

  wire start    = (pos == '0);
  wire last     = bit_vld && (pos == CW'(WIN_BITS - 1));
  wire nib_done = bit_vld && (&pos[1:0]);
  wire [3:0] nib = {nsh, bit_in};

  wire [CW-1:0] ones_nxt = ones + CW'(bit_in);
  wire mono_bad = (ones_nxt < CW'(ONES_LO)) || (ones_nxt > CW'(ONES_HI));

  wire [SW-1:0] sumsq_nxt = sumsq + (nib_done ? SW'({pk[nib], 1'b1}) : '0);
  wire [SW+3:0] s16 = {sumsq_nxt, 4'b0};
  wire poker_bad = (s16 < (SW+4)'(PK_LO_T)) || (s16 > (SW+4)'(PK_HI_T));

  wire       differ  = (bit_in != wr_bit);
  wire [2:0] len_nx  = (start || differ) ? 3'd1 : (wr_len == 3'd6 ? 3'd6 : wr_len + 3'd1);
  wire       close_a = bit_vld && !start && differ;
  wire [3:0] idx_a   = wr_bit ? 4'(wr_len) + 4'd5 : 4'(wr_len) - 4'd1;
  wire [3:0] idx_b   = bit_in ? 4'(len_nx) + 4'd5 : 4'(len_nx) - 4'd1;

  logic [CW-1:0] rc_nxt [12];
  logic          runs_bad;
  always_comb begin
    runs_bad = 1'b0;
    for (int i = 0; i < 12; i++) begin
      rc_nxt[i] = rc[i] + CW'(close_a && idx_a == 4'(i)) + CW'(last && idx_b == 4'(i));
      if (rc_nxt[i] < CW'(RUN_LO[i % 6]) || rc_nxt[i] > CW'(RUN_HI[i % 6]))
        runs_bad = 1'b1;
    end
  end

  wire same     = rep_seen && (bit_in == rep_bit);
  wire hit_long = bit_vld && same && (rep_len == RW'(LONG_RUN - 1));
  wire hit_nois = bit_vld && same && (rep_len == RW'(NOISE_RUN - 1));
  wire hit_stk  = word_vld && prev_ok && (word_in == prev_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0; ones <= '0; nsh <= '0; sumsq <= '0;
      for (int i = 0; i < 16; i++) pk[i] <= '0;
      for (int i = 0; i < 12; i++) rc[i] <= '0;
      wr_bit <= 1'b0; wr_len <= 3'd0;
      rep_seen <= 1'b0; rep_bit <= 1'b0; rep_len <= '0;
      prev_ok <= 1'b0; prev_word <= '0;
      win_done <= 1'b0; fail_monobit <= 1'b0; fail_poker <= 1'b0; fail_runs <= 1'b0;
      fail_longrun <= 1'b0; fail_noise <= 1'b0; fail_stuck <= 1'b0;
    end else begin
      win_done     <= last;
      fail_monobit <= last && mono_bad;
      fail_poker   <= last && poker_bad;
      fail_runs    <= last && runs_bad;
      fail_longrun <= hit_long;
      fail_noise   <= hit_nois;
      fail_stuck   <= hit_stk;
      if (word_vld) begin
        prev_ok   <= 1'b1;
        prev_word <= word_in;
      end
      if (bit_vld) begin
        rep_seen <= 1'b1;
        rep_bit  <= bit_in;
        rep_len  <= !same ? RW'(1) : (rep_len == RW'(NOISE_RUN) ? rep_len : rep_len + RW'(1));
        nsh      <= {nsh[1:0], bit_in};
        wr_bit   <= bit_in;
        wr_len   <= len_nx;
        if (last) begin
          pos <= '0; ones <= '0; sumsq <= '0;
          for (int i = 0; i < 16; i++) pk[i] <= '0;
          for (int i = 0; i < 12; i++) rc[i] <= '0;
        end else begin
          pos   <= pos + CW'(1);
          ones  <= ones_nxt;
          sumsq <= sumsq_nxt;
          if (nib_done) pk[nib] <= pk[nib] + NW'(1);
          for (int i = 0; i < 12; i++) rc[i] <= rc_nxt[i];
        end
      end
    end
  end
endmodule

// File: rtl/rng_health_mon_chk.sv
module rng_health_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_vld,
  input logic word_vld,
  input logic win_done,
  input logic fail_monobit,
  input logic fail_poker,
  input logic fail_runs,
  input logic fail_longrun,
  input logic fail_noise,
  input logic fail_stuck
);
  assert_verdict_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_monobit || fail_poker || fail_runs) |-> win_done);
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> !win_done);
  assert_longrun_from_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_longrun |-> $past(bit_vld));
  assert_noise_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_noise |=> !fail_noise);
  assert_noise_long_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fail_noise && fail_longrun));
  assert_stuck_from_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_stuck |-> $past(word_vld));
endmodule

bind rng_health_mon rng_health_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .word_vld(word_vld),
  .win_done(win_done), .fail_monobit(fail_monobit), .fail_poker(fail_poker),
  .fail_runs(fail_runs), .fail_longrun(fail_longrun), .fail_noise(fail_noise),
  .fail_stuck(fail_stuck)
);

// File: tb/tb_rng_health_mon.sv
module tb_rng_health_mon;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, bit_vld, bit_in, word_vld;
  logic [31:0] word_in;
  logic win_done, fail_monobit, fail_poker, fail_runs, fail_longrun, fail_noise, fail_stuck;

  rng_health_mon dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .word_vld(word_vld), .word_in(word_in), .win_done(win_done),
    .fail_monobit(fail_monobit), .fail_poker(fail_poker), .fail_runs(fail_runs),
    .fail_longrun(fail_longrun), .fail_noise(fail_noise), .fail_stuck(fail_stuck)
  );

  int n_cmp = 0, n_bad = 0;
  bit wb [20000];
  int wn = 0, wins = 0;
  bit have_bit = 0, rbit = 0;
  int rlen = 0;
  bit have_w = 0;
  logic [31:0] pw = '0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit f_mono();
    int n = 0;
    for (int i = 0; i < 20000; i++) n += int'(wb[i]);
    return (n < 9655 || n > 10345);
  endfunction

  function automatic bit f_poker();
    int c [16];
    longint ss = 0, s;
    for (int k = 0; k < 16; k++) c[k] = 0;
    for (int i = 0; i < 5000; i++) c[{wb[4*i], wb[4*i+1], wb[4*i+2], wb[4*i+3]}]++;
    for (int k = 0; k < 16; k++) ss += longint'(c[k]) * c[k];
    s = 16 * ss - 25000000;
    return (s < 5150 || s > 287000);
  endfunction

  function automatic bit f_runs();
    int r0 [7], r1 [7], lo [7], hi [7];
    int len = 1, l;
    bit bad = 0;
    lo = '{0, 2267, 1079, 502, 223, 90, 90};
    hi = '{0, 2733, 1421, 748, 402, 223, 223};
    for (int k = 0; k < 7; k++) begin r0[k] = 0; r1[k] = 0; end
    for (int i = 1; i <= 20000; i++) begin
      if (i < 20000 && wb[i] == wb[i-1]) len++;
      else begin
        l = (len > 6) ? 6 : len;
        if (wb[i-1]) r1[l]++; else r0[l]++;
        len = 1;
      end
    end
    for (int k = 1; k < 7; k++)
      if (r0[k] < lo[k] || r0[k] > hi[k] || r1[k] < lo[k] || r1[k] > hi[k]) bad = 1;
    return bad;
  endfunction

  task automatic step(input bit bv, input bit b, input bit wv, input logic [31:0] w);
    bit e_done, e_mono, e_pk, e_runs, e_long, e_noise, e_stuck;
    e_done = 0; e_mono = 0; e_pk = 0; e_runs = 0; e_long = 0; e_noise = 0; e_stuck = 0;
    @(negedge clk);
    bit_vld = bv; bit_in = b; word_vld = wv; word_in = w;
    if (bv) begin
      if (have_bit && b == rbit) rlen++; else rlen = 1;
      rbit = b; have_bit = 1;
      e_long  = (rlen == 34);
      e_noise = (rlen == 48);
      wb[wn] = b; wn++;
      if (wn == 20000) begin
        e_done = 1; e_mono = f_mono(); e_pk = f_poker(); e_runs = f_runs();
        wn = 0; wins++;
      end
    end
    if (wv) begin
      e_stuck = have_w && (w == pw);
      pw = w; have_w = 1;
    end
    @(posedge clk); #1;
    chk("R2", "win_done", int'(win_done), int'(e_done));
    chk("R3", "fail_monobit", int'(fail_monobit), int'(e_mono));
    chk("R4", "fail_poker", int'(fail_poker), int'(e_pk));
    chk("R5", "fail_runs", int'(fail_runs), int'(e_runs));
    chk("R6", "fail_longrun", int'(fail_longrun), int'(e_long));
    chk("R7", "fail_noise", int'(fail_noise), int'(e_noise));
    chk("R8", "fail_stuck", int'(fail_stuck), int'(e_stuck));
  endtask

  task automatic pick_word(output bit wv, output logic [31:0] w);
    wv = ($urandom % 8) == 0;
    w = (have_w && ($urandom % 3) == 0) ? pw : $urandom;
  endtask

  task automatic run_bits(input int n, input bit b);
    bit wv; logic [31:0] w;
    for (int i = 0; i < n; i++) begin pick_word(wv, w); step(1'b1, b, wv, w); end
  endtask

  task automatic check_idle(input string tag);
    chk(tag, "win_done", int'(win_done), 0);
    chk(tag, "fail_monobit", int'(fail_monobit), 0);
    chk(tag, "fail_poker", int'(fail_poker), 0);
    chk(tag, "fail_runs", int'(fail_runs), 0);
    chk(tag, "fail_longrun", int'(fail_longrun), 0);
    chk(tag, "fail_noise", int'(fail_noise), 0);
    chk(tag, "fail_stuck", int'(fail_stuck), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit wv, bv, b; logic [31:0] w; int tgt;
    void'($urandom(32'd7919));
    rst_n = 1'b0; bit_vld = 1'b1; bit_in = 1'b1; word_vld = 1'b1; word_in = '0;
    repeat (4) @(posedge clk);
    #1 check_idle("R1");
    @(negedge clk);
    bit_vld = 1'b0; word_vld = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #1 check_idle("R1");

    // R6: 33 identical bits give no pulse; R7 and R6 on a 50-bit run; exact 34 zeros
    run_bits(33, 1'b1); run_bits(1, 1'b0);
    run_bits(50, 1'b1); run_bits(34, 1'b0); run_bits(1, 1'b1);
    // R8 directed: a word repeated while word_vld is low is ignored, then a real repeat
    step(1'b0, 1'b0, 1'b1, 32'hA5A5_0001);
    step(1'b0, 1'b0, 1'b0, 32'hA5A5_0001);
    step(1'b0, 1'b0, 1'b1, 32'hA5A5_0002);
    step(1'b0, 1'b0, 1'b1, 32'hA5A5_0002);
    // Window 1: unbiased random bits with gaps (R2..R5)
    tgt = wins + 1;
    while (wins < tgt) begin
      bv = ($urandom % 4) != 0; b = $urandom % 2; pick_word(wv, w);
      step(bv, b, wv, w);
    end
    // Window 2: bits biased toward one
    tgt = wins + 1;
    while (wins < tgt) begin
      b = ($urandom % 4) != 0; pick_word(wv, w);
      step(1'b1, b, wv, w);
    end
    // Window 3: alternating pattern ending in a run of ones
    tgt = wins + 1;
    while (wn < 19980) begin pick_word(wv, w); step(1'b1, wn[0], wv, w); end
    while (wins < tgt) begin pick_word(wv, w); step(1'b1, 1'b1, wv, w); end
    // Window 4: run continues across the boundary (R6), then random bits
    run_bits(20, 1'b1); run_bits(1, 1'b0);
    tgt = wins + 1;
    while (wins < tgt) begin
      b = $urandom % 2; pick_word(wv, w);
      step(1'b1, b, wv, w);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule